// File: doc/BRIEF.md
# Windowed Branch Event Threshold Monitor

This block watches the per-cycle retirement strobes of a processor pipeline. It raises a one-cycle trip pulse when the branch event counts inside a window reach programmable thresholds. A window counter advances on one selectable class of retired instruction. When it reaches the programmed size, the window closes and both event counters start again from zero. Each of the two event counters has its own enable, 7-bit threshold and counting mode. An AND or OR rule merges their threshold conditions, and a disabled counter takes no part in that rule. A trip can also raise a freeze request toward a branch-record unit.

All configuration arrives as static inputs that software registers drive. The intended software defaults are a window size of 1023, window source 0, thresholds of 127, OR rule, accumulate mode, and the freeze and guest-block bits cleared. A small controller has four states. OFF is entered whenever the global enable is low, and it clears everything. HOLD is entered while the guest block bit and the guest-mode flag are both high, and it freezes all counts. RUN counts events. TRIP lasts one cycle, asserts the pulse and restarts all counts.

The controller takes these transitions. Any state goes to OFF when the enable is low. Otherwise any state goes to HOLD while guest suppression is active. RUN goes to TRIP when the combined condition is true. TRIP goes back to RUN. OFF and HOLD go to RUN once they are released. RUN stays in RUN when no condition is met.

Top module: `branch_window_monitor`

## Requirements
- R1: After reset, trip, freeze_req, count0, count1 and win_count are all 0.
- R2: In RUN, win_count rises by one per cycle in which the selected retire strobe is high. The select codes are 0 for instructions (ev_retire[0]), 1 for branches (ev_retire[1]), 2 for returns (ev_retire[2]) and 3 for indirect branches (ev_retire[3]).
- R3: If the selected strobe is high while win_count equals cfg_win_size, then win_count and both event counts read 0 in the next cycle. With a size of 0, this happens on every selected event.
- R4: In accumulate mode (cfg_run_mode bit 0), each cycle with the counter's match strobe high adds one to the count. The count saturates at 127.
- R5: In run mode (cfg_run_mode bit 1), a cycle with the qualify strobe high and the match strobe low clears the count. If both strobes are high, match takes priority.
- R6: The condition of a counter is registered as enabled and count >= threshold. In OR mode (cfg_and_mode 0), trip goes high two cycles after any enabled count first reaches its threshold.
- R7: In AND mode (cfg_and_mode 1), every enabled counter must hold its condition. A disabled counter is ignored. With no counter enabled, the block never trips.
- R8: trip lasts exactly one cycle. During that cycle both counts and win_count read 0, and events seen in that cycle are dropped. A threshold of 0 gives a trip every third cycle.
- R9: freeze_req is high in the trip cycle exactly when cfg_freeze_en was high in the cycle before it. It is never high without trip.
- R10: While cfg_enable, cfg_guest_block and guest_mode are all high, the window and enabled counts hold their values and no trip occurs.
- R11: While cfg_enable is low, both counts and win_count return to 0 and no trip occurs.
- R12: A counter whose cfg_cnt_en bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Global enable |
| cfg_guest_block | input | 1 | Suppress while in guest mode |
| guest_mode | input | 1 | Processor is running a guest |
| cfg_and_mode | input | 1 | 1 = AND rule, 0 = OR rule |
| cfg_freeze_en | input | 1 | Raise freeze request on trip |
| cfg_win_size | input | 10 | Window length in selected events |
| cfg_win_sel | input | 2 | Window advance source |
| cfg_cnt_en | input | 2 | Per-counter enable |
| cfg_run_mode | input | 2 | Per-counter consecutive-run mode |
| cfg_thresh0 | input | 7 | Counter 0 threshold |
| cfg_thresh1 | input | 7 | Counter 1 threshold |
| ev_retire | input | 4 | Retire strobes: instr, branch, return, indirect |
| ev_match | input | 2 | Per-counter matching event |
| ev_qual | input | 2 | Per-counter qualifying event |
| trip | output | 1 | One-cycle trip pulse |
| freeze_req | output | 1 | Branch-record freeze request |
| count0 | output | 7 | Counter 0 value |
| count1 | output | 7 | Counter 1 value |
| win_count | output | 10 | Window counter value |

## Verification
The counts and win_count change one cycle after the strobe that moves them. A counter's condition register follows one cycle later, and trip with freeze_req follows one cycle after that, so trip appears two cycles after a count reaches its threshold. The bench drives every input just after a falling edge. Its reference model then steps through the rising edge, and it compares all outputs at the next falling edge, which keeps every result in the cycle where it is due. Directed phases also count the cycles to the first trip explicitly, to pin down that two-cycle latency and the three-cycle period at a threshold of 0.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2,
        ST_TRIP = 2'd3
    } bwm_state_t;

    localparam int NUM_CTR = 2;
    localparam int NUM_SRC = 4;
endpackage

// File: rtl/bwm_window.sv
module bwm_window #(
    parameter int WIN_W = 10,
    parameter int SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      sel,
    input  logic [(1<<SEL_W)-1:0] src,
    input  logic [WIN_W-1:0]      size,
    input  logic                  clear,
    input  logic                  run,
    output logic [WIN_W-1:0]      win_q,
    output logic                  wrap
);
    logic adv;

    always_comb begin
        adv  = src[sel];
        wrap = run && adv && (win_q == size);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            win_q <= '0;
        else if (clear || wrap)
            win_q <= '0;
        else if (run && adv)
            win_q <= win_q + WIN_W'(1);
    end
endmodule

// File: rtl/bwm_event_ctr.sv
module bwm_event_ctr #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] thresh,
    input  logic             run_mode,
    input  logic             match,
    input  logic             qual,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear || !en) begin
            count <= '0;
        end else if (run) begin
            if (match) begin
                if (count != CNT_MAX)
                    count <= count + CNT_W'(1);
            end else if (run_mode && qual) begin
                count <= '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hit <= 1'b0;
        else if (clear || !en || !run)
            hit <= 1'b0;
        else
            hit <= (count >= thresh);
    end
endmodule

// File: rtl/bwm_ctrl.sv
module bwm_ctrl
    import bwm_pkg::*;
#(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         suppress,
    input  logic         and_mode,
    input  logic         freeze_en,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] en,
    output logic         trip,
    output logic         freeze,
    output logic         ctr_clear,
    output logic         ctr_run
);
    bwm_state_t state, nxt;
    logic any_hit, all_hit, cond;

    always_comb begin
        any_hit = |(hit & en);
        all_hit = (|en) && (&(hit | ~en));
        cond    = and_mode ? all_hit : any_hit;
    end

    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = ST_OFF;
        end else if (suppress) begin
            nxt = ST_HOLD;
        end else begin
            unique case (state)
                ST_OFF:  nxt = ST_RUN;
                ST_HOLD: nxt = ST_RUN;
                ST_RUN:  nxt = cond ? ST_TRIP : ST_RUN;
                ST_TRIP: nxt = ST_RUN;
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            freeze <= 1'b0;
        end else begin
            state  <= nxt;
            freeze <= (nxt == ST_TRIP) && freeze_en;
        end
    end

    always_comb begin
        trip      = (state == ST_TRIP);
        ctr_clear = (nxt == ST_OFF) || (nxt == ST_TRIP);
        ctr_run   = (nxt == ST_RUN) && (state != ST_TRIP);
    end
endmodule

// File: rtl/branch_window_monitor.sv
module branch_window_monitor
    import bwm_pkg::*;
#(
    parameter int WIN_W = 10,
    parameter int CNT_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_enable,
    input  logic                 cfg_guest_block,
    input  logic                 guest_mode,
    input  logic                 cfg_and_mode,
    input  logic                 cfg_freeze_en,
    input  logic [WIN_W-1:0]     cfg_win_size,
    input  logic [1:0]           cfg_win_sel,
    input  logic [NUM_CTR-1:0]   cfg_cnt_en,
    input  logic [NUM_CTR-1:0]   cfg_run_mode,
    input  logic [CNT_W-1:0]     cfg_thresh0,
    input  logic [CNT_W-1:0]     cfg_thresh1,
    input  logic [NUM_SRC-1:0]   ev_retire,
    input  logic [NUM_CTR-1:0]   ev_match,
    input  logic [NUM_CTR-1:0]   ev_qual,
    output logic                 trip,
    output logic                 freeze_req,
    output logic [CNT_W-1:0]     count0,
    output logic [CNT_W-1:0]     count1,
    output logic [WIN_W-1:0]     win_count
);
    logic                 ctr_clear, ctr_run, wrap, suppress;
    logic [NUM_CTR-1:0]   hit;
    logic [CNT_W-1:0]     thr   [NUM_CTR];
    logic [CNT_W-1:0]     cnt_v [NUM_CTR];

    always_comb begin
        suppress = cfg_guest_block && guest_mode;
        thr[0]   = cfg_thresh0;
        thr[1]   = cfg_thresh1;
        count0   = cnt_v[0];
        count1   = cnt_v[1];
    end

    bwm_ctrl #(.N(NUM_CTR)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .suppress  (suppress),
        .and_mode  (cfg_and_mode),
        .freeze_en (cfg_freeze_en),
        .hit       (hit),
        .en        (cfg_cnt_en),
        .trip      (trip),
        .freeze    (freeze_req),
        .ctr_clear (ctr_clear),
        .ctr_run   (ctr_run)
    );

    bwm_window #(.WIN_W(WIN_W), .SEL_W(2)) win_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cfg_win_sel),
        .src   (ev_retire),
        .size  (cfg_win_size),
        .clear (ctr_clear),
        .run   (ctr_run),
        .win_q (win_count),
        .wrap  (wrap)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        bwm_event_ctr #(.CNT_W(CNT_W)) ctr_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (cfg_cnt_en[g]),
            .thresh   (thr[g]),
            .run_mode (cfg_run_mode[g]),
            .match    (ev_match[g]),
            .qual     (ev_qual[g]),
            .clear    (ctr_clear || wrap),
            .run      (ctr_run),
            .count    (cnt_v[g]),
            .hit      (hit[g])
        );
    end
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
    parameter int WIN_W = 10,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             cfg_guest_block,
    input logic             guest_mode,
    input logic [1:0]       cfg_cnt_en,
    input logic             trip,
    input logic             freeze_req,
    input logic [CNT_W-1:0] count0,
    input logic [CNT_W-1:0] count1,
    input logic [WIN_W-1:0] win_count
);
    logic susp;
    assign susp = cfg_enable && cfg_guest_block && guest_mode;

    AST_TRIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) trip |=> !trip); // R8
    AST_TRIP_RESTART: assert property (@(posedge clk) disable iff (!rst_n) trip |-> (count0 == '0 && count1 == '0 && win_count == '0)); // R8
    AST_FREEZE_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n) freeze_req |-> trip); // R9
    AST_GUEST_HOLD_WIN: assert property (@(posedge clk) disable iff (!rst_n) susp |=> ($stable(win_count) && !trip)); // R10
    AST_GUEST_HOLD_CNT0: assert property (@(posedge clk) disable iff (!rst_n) (susp && cfg_cnt_en[0]) |=> $stable(count0)); // R10
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !cfg_enable |=> (count0 == '0 && count1 == '0 && win_count == '0 && !trip)); // R11
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !cfg_cnt_en[1] |=> (count1 == '0)); // R12
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (count0 != $past(count0)) |-> (count0 == '0 || count0 == $past(count0) + CNT_W'(1))); // R4
endmodule

bind branch_window_monitor bwm_checker #(.WIN_W(WIN_W), .CNT_W(CNT_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_enable      (cfg_enable),
    .cfg_guest_block (cfg_guest_block),
    .guest_mode      (guest_mode),
    .cfg_cnt_en      (cfg_cnt_en),
    .trip            (trip),
    .freeze_req      (freeze_req),
    .count0          (count0),
    .count1          (count1),
    .win_count       (win_count)
);

// File: tb/branch_window_monitor_tb.sv
`timescale 1ns/1ps
module branch_window_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0, cfg_guest_block = 1'b0, guest_mode = 1'b0;
    logic       cfg_and_mode = 1'b0, cfg_freeze_en = 1'b0;
    logic [9:0] cfg_win_size = 10'd1023;
    logic [1:0] cfg_win_sel = 2'd0, cfg_cnt_en = 2'b00, cfg_run_mode = 2'b00;
    logic [6:0] cfg_thresh0 = 7'd127, cfg_thresh1 = 7'd127;
    logic [3:0] ev_retire = '0;
    logic [1:0] ev_match = '0, ev_qual = '0;
    logic       trip, freeze_req;
    logic [6:0] count0, count1;
    logic [9:0] win_count;

    int n_tests = 0, n_fail = 0;
    int m_st = 0;             // 0 off, 1 run, 2 hold, 3 trip
    logic [6:0] m_cnt [2];
    logic [1:0] m_hit = '0;
    logic [9:0] m_win = '0;
    logic       m_frz = 1'b0;
    string      tag = "R1";

    always #4 clk = ~clk;

    branch_window_monitor dut_i (.*);

    initial begin
        #(200000 * 8);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(string t, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    function automatic logic [6:0] sat_inc(logic [6:0] v);
        return (v == 7'd127) ? v : v + 7'd1;
    endfunction

    // Reference model advanced across one rising edge, then compared.
    task automatic tick();
        int nst; logic clr, run, adv, wrap, cond, anyh, allh;
        logic [6:0] thr [2]; logic [6:0] nc [2]; logic [1:0] nh;
        thr[0] = cfg_thresh0; thr[1] = cfg_thresh1;
        anyh = |(m_hit & cfg_cnt_en);
        allh = (cfg_cnt_en != 0) && ((m_hit[0] || !cfg_cnt_en[0]) && (m_hit[1] || !cfg_cnt_en[1]));
        cond = cfg_and_mode ? allh : anyh;
        if (!cfg_enable) nst = 0;
        else if (cfg_guest_block && guest_mode) nst = 2;
        else if (m_st == 1 && cond) nst = 3;
        else nst = 1;
        clr  = (nst == 0) || (nst == 3);
        run  = (nst == 1) && (m_st != 3);
        adv  = ev_retire[cfg_win_sel];
        wrap = run && adv && (m_win == cfg_win_size);
        for (int i = 0; i < 2; i++) begin
            if (clr || wrap || !cfg_cnt_en[i]) nc[i] = 0;
            else if (!run) nc[i] = m_cnt[i];
            else if (ev_match[i]) nc[i] = sat_inc(m_cnt[i]);
            else if (cfg_run_mode[i] && ev_qual[i]) nc[i] = 0;
            else nc[i] = m_cnt[i];
            nh[i] = (clr || wrap || !cfg_cnt_en[i] || !run) ? 1'b0 : (m_cnt[i] >= thr[i]);
        end
        @(posedge clk);
        m_frz = (nst == 3) && cfg_freeze_en;
        m_win = (clr || wrap) ? 10'd0 : (run && adv) ? m_win + 10'd1 : m_win;
        m_cnt[0] = nc[0]; m_cnt[1] = nc[1]; m_hit = nh; m_st = nst;
        @(negedge clk);
        n_tests++;
        if (trip !== (m_st == 3) || freeze_req !== m_frz || count0 !== m_cnt[0] ||
            count1 !== m_cnt[1] || win_count !== m_win) begin
            n_fail++;
            $display("FAIL %s: trip/frz/c0/c1/win actual=%b %b %0d %0d %0d expected=%b %b %0d %0d %0d",
                     tag, trip, freeze_req, count0, count1, win_count,
                     (m_st == 3), m_frz, m_cnt[0], m_cnt[1], m_win);
        end
    endtask

    task automatic quiet();
        ev_retire = '0; ev_match = '0; ev_qual = '0;
    endtask

    task automatic go_off();
        quiet(); cfg_enable = 1'b0; guest_mode = 1'b0; cfg_guest_block = 1'b0;
        tick();
        cfg_enable = 1'b1;
    endtask

    initial begin
        int trips, first;
        m_cnt[0] = '0; m_cnt[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 trip", trip, 0); chk("R1 freeze", freeze_req, 0);
        chk("R1 count0", count0, 0); chk("R1 count1", count1, 0); chk("R1 win", win_count, 0);

        // R2: each window source class
        for (int s = 0; s < 4; s++) begin
            tag = "R2"; go_off(); cfg_win_sel = 2'(s); cfg_win_size = 10'd1023;
            for (int k = 0; k < 5; k++) begin
                quiet(); ev_retire = 4'(1 << s); tick();
                quiet(); ev_retire = ~4'(1 << s); tick();
            end
            chk("R2 window advance by selected class", win_count, 5);
        end

        // R3: window wrap clears counters
        tag = "R3"; go_off(); cfg_win_sel = 2'd0; cfg_win_size = 10'd3; cfg_cnt_en = 2'b01;
        cfg_thresh0 = 7'd127;
        for (int k = 0; k < 3; k++) begin quiet(); ev_retire = 4'b0001; ev_match = 2'b01; tick(); end
        chk("R3 before wrap win", win_count, 3); chk("R3 before wrap count0", count0, 3);
        quiet(); ev_retire = 4'b0001; ev_match = 2'b01; tick();
        chk("R3 wrap win", win_count, 0); chk("R3 wrap count0", count0, 0);
        cfg_win_size = 10'd0;
        for (int k = 0; k < 4; k++) begin quiet(); ev_retire = 4'b0001; ev_match = 2'b01; tick(); end
        chk("R3 size zero", count0, 0);

        // R4/R7: saturation under AND with an idle partner
        tag = "R4"; go_off(); cfg_win_size = 10'd1023; cfg_cnt_en = 2'b11; cfg_and_mode = 1'b1;
        cfg_thresh0 = 7'd127; cfg_thresh1 = 7'd127;
        for (int k = 0; k < 150; k++) begin quiet(); ev_match = 2'b01; tick(); end
        chk("R4 saturate at 127", count0, 127);
        chk("R7 AND needs both", trip, 0);

        // R5: consecutive-run mode
        tag = "R5"; go_off(); cfg_cnt_en = 2'b01; cfg_run_mode = 2'b01; cfg_and_mode = 1'b0;
        for (int k = 0; k < 3; k++) begin quiet(); ev_match = 2'b01; ev_qual = 2'b01; tick(); end
        chk("R5 run count", count0, 3);
        quiet(); ev_qual = 2'b01; tick();
        chk("R5 qualify without match clears", count0, 0);
        cfg_run_mode = 2'b00;
        for (int k = 0; k < 2; k++) begin quiet(); ev_match = 2'b01; tick(); end
        quiet(); ev_qual = 2'b01; tick();
        chk("R5 accumulate ignores qualify", count0, 2);

        // R6 OR latency, R7 AND with one disabled
        for (int am = 0; am < 2; am++) begin
            tag = am ? "R7" : "R6"; go_off(); cfg_and_mode = am[0]; cfg_cnt_en = 2'b01;
            cfg_thresh0 = 7'd5; first = 0;
            for (int k = 1; k <= 10; k++) begin
                quiet(); ev_match = 2'b01; tick();
                if (trip && first == 0) first = k;
            end
            chk(am ? "R7 AND single enabled trip cycle" : "R6 OR trip cycle", first, 7);
        end
        tag = "R7"; go_off(); cfg_cnt_en = 2'b00; cfg_thresh0 = 7'd0; cfg_thresh1 = 7'd0;
        trips = 0;
        for (int k = 0; k < 10; k++) begin quiet(); ev_match = 2'b11; tick(); trips += int'(trip); end
        chk("R7 none enabled never trips", trips, 0);

        // R8/R9: threshold zero cadence, freeze follows enable
        tag = "R8"; go_off(); cfg_cnt_en = 2'b01; cfg_freeze_en = 1'b1; cfg_and_mode = 1'b0;
        trips = 0;
        for (int k = 0; k < 9; k++) begin
            quiet(); tick(); trips += int'(trip);
            chk("R9 freeze equals trip", freeze_req, trip);
        end
        chk("R8 threshold 0 trips every third cycle", trips, 3);
        cfg_freeze_en = 1'b0; trips = 0;
        for (int k = 0; k < 9; k++) begin quiet(); tick(); trips += int'(freeze_req); end
        chk("R9 freeze off", trips, 0);

        // R10 guest hold, R11 off clears, R12 disabled zero
        tag = "R10"; go_off(); cfg_cnt_en = 2'b11; cfg_thresh0 = 7'd127; cfg_thresh1 = 7'd127;
        for (int k = 0; k < 3; k++) begin quiet(); ev_match = 2'b11; ev_retire = 4'b0001; tick(); end
        cfg_guest_block = 1'b1; guest_mode = 1'b1;
        for (int k = 0; k < 5; k++) begin quiet(); ev_match = 2'b11; ev_retire = 4'b1111; tick(); end
        chk("R10 count held", count0, 3); chk("R10 window held", win_count, 3);
        tag = "R11"; cfg_enable = 1'b0; quiet(); tick();
        chk("R11 off clears count", count1, 0); chk("R11 off clears window", win_count, 0);
        tag = "R12"; go_off(); cfg_cnt_en = 2'b10;
        for (int k = 0; k < 4; k++) begin quiet(); ev_match = 2'b11; tick(); end
        chk("R12 disabled reads zero", count0, 0);

        // Random phase against the model
        tag = "R6 random"; void'($urandom(32'h5eed));
        for (int blk = 0; blk < 60; blk++) begin
            cfg_win_size    = ($urandom % 3 == 0) ? 10'd1023 : 10'($urandom % 24);
            cfg_win_sel     = 2'($urandom);
            cfg_cnt_en      = 2'($urandom);
            cfg_run_mode    = 2'($urandom);
            cfg_and_mode    = 1'($urandom);
            cfg_freeze_en   = 1'($urandom);
            cfg_thresh0     = ($urandom % 4 == 0) ? 7'($urandom) : 7'($urandom % 12);
            cfg_thresh1     = ($urandom % 4 == 0) ? 7'($urandom) : 7'($urandom % 12);
            cfg_guest_block = 1'($urandom);
            for (int k = 0; k < 200; k++) begin
                cfg_enable = ($urandom % 50) != 0;
                guest_mode = ($urandom % 8) == 0;
                ev_retire  = 4'($urandom);
                ev_match   = 2'($urandom);
                ev_qual    = 2'($urandom);
                tick();
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule